// File: doc/BRIEF.md
# Dual-Rail Parity-Corrected Word Memory

This block is a small synchronous memory, addressed by word, built to survive single upsets in its stored nodes. Every data bit is kept on two nodes: one holds the value and the other holds its inverse. Each word also carries one even-parity bit, and that bit is held as a true/inverse pair as well. A write fills all of these nodes in one cycle.

On a read, the block compares each node pair. A pair whose two nodes agree is a bit that has been corrupted. The position of the fault comes from this per-bit check, so the single parity bit only has to supply the value of that bit. A lone flagged data bit is rebuilt so that the word matches its stored parity. A flagged parity pair is reported with the data left as it is. Any worse pattern is reported as uncorrectable, and the true-node data is passed through.

A test port inverts any one stored node at a chosen address. It is used to model an upset and to check the recovery logic. Reads take one cycle. Sensing is modelled with inverted polarity: each sense line is the complement of its node, and an inverter restores the stored level.

Top module: `drpr_ram`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rd_valid`, `rd_corrected` and `rd_uncorrectable` are 0 and `rd_data` is all zeros.
- R2: A write stores `wr_data` on the true nodes, its bitwise inverse on the inverse nodes, and even parity (XOR of all data bits) on the parity true node with its inverse on the parity inverse node. A later read of a clean word returns `wr_data` with both flags low.
- R3: A read accepted at one clock edge shows its result at the next edge, with `rd_valid` high for exactly that one cycle.
- R4: A read of the address being written in the same cycle returns the contents from before the write.
- R5: After one data node of a word has been inverted (true or inverse node, any bit), a read returns the originally written data with `rd_corrected`=1 and `rd_uncorrectable`=0.
- R6: After one parity node of a word has been inverted, a read returns the written data with `rd_corrected`=1 and `rd_uncorrectable`=0.
- R7: After any two distinct nodes of one word have been inverted, a read gives `rd_uncorrectable`=1 and `rd_corrected`=0. `rd_data` equals the written data XOR the set of data true nodes that were inverted.
- R8: A fault pulse (`flt_en`=1) inverts exactly one node. `flt_sel` selects it: 0 = data true node of bit `flt_bit`, 1 = data inverse node of bit `flt_bit`, 2 = parity true node, 3 = parity inverse node. Other words are left unchanged.
- R9: If a fault and a write target the same address in the same cycle, the write takes effect and the fault is dropped.
- R10: In cycles with no read result, `rd_valid` and both flags are 0 and `rd_data` keeps its last value. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read word address |
| flt_en | input | 1 | Fault-injection strobe |
| flt_addr | input | AW | Address of the node to invert |
| flt_sel | input | 2 | Node kind: 0 data true, 1 data inverse, 2 parity true, 3 parity inverse |
| flt_bit | input | BW | Data bit index for kinds 0 and 1 |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | W | Corrected (or passed-through) read data |
| rd_corrected | output | 1 | A single upset was found and handled |
| rd_uncorrectable | output | 1 | Upset pattern beyond repair |

## Verification
Assertions run on every cycle and cover the following:
- what a write stores in all four node banks;
- the fact that a fault inverts only its target node and leaves the partner node alone;
- the one-cycle read timing;
- the rule that the flags are exclusive and low when idle;
- the rule that a repaired single-bit word always has parity equal to its stored parity bit.

Some behaviour can only be shown by the bench's scenarios. These are: that the repaired word equals what was written, for every single-node upset; that every two-node upset in one word is reported as uncorrectable, with the expected pass-through data; the old-data result of a read during a write; the write-over-fault priority; and isolation between addresses.

// File: rtl/drpr_pkg.sv
package drpr_pkg;

  // Which stored node a fault pulse inverts
  typedef enum logic [1:0] {
    NODE_DT = 2'd0,  // data true node
    NODE_DC = 2'd1,  // data inverse node
    NODE_PT = 2'd2,  // parity true node
    NODE_PC = 2'd3   // parity inverse node
  } node_sel_e;

  function automatic int bit_idx_w(input int w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction

endpackage

// File: rtl/drpr_store.sv
module drpr_store
  import drpr_pkg::*;
#(
  parameter int W  = 16,
  parameter int D  = 32,
  parameter int AW = (D > 1) ? $clog2(D) : 1,
  parameter int BW = bit_idx_w(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic          flt_en,
  input  logic [AW-1:0] flt_addr,
  input  node_sel_e     flt_sel,
  input  logic [BW-1:0] flt_bit,
  output logic [W-1:0]  sns_true,
  output logic [W-1:0]  sns_comp,
  output logic          sns_pt,
  output logic          sns_pc
);

  // Node banks: no reset so that they map onto RAM resources
  logic [W-1:0] bank_t  [D];
  logic [W-1:0] bank_c  [D];
  logic         bank_pt [D];
  logic         bank_pc [D];

  logic wr_par;
  logic flt_live;

  assign wr_par   = ^wr_data;
  assign flt_live = flt_en && !(wr_en && (wr_addr == flt_addr));

  always_ff @(posedge clk) begin
    if (wr_en) begin
      bank_t[wr_addr]  <= wr_data;
      bank_c[wr_addr]  <= ~wr_data;
      bank_pt[wr_addr] <= wr_par;
      bank_pc[wr_addr] <= ~wr_par;
    end
    if (flt_live) begin
      case (flt_sel)
        NODE_DT: bank_t[flt_addr][flt_bit] <= ~bank_t[flt_addr][flt_bit];
        NODE_DC: bank_c[flt_addr][flt_bit] <= ~bank_c[flt_addr][flt_bit];
        NODE_PT: bank_pt[flt_addr]         <= ~bank_pt[flt_addr];
        default: bank_pc[flt_addr]         <= ~bank_pc[flt_addr];
      endcase
    end
  end

  // Sensing model: each line rises only for a stored 0; an inverter restores level
  logic [W-1:0] line_t, line_c;
  logic         line_pt, line_pc;

  always_comb begin
    line_t   = ~bank_t[rd_addr];
    line_c   = ~bank_c[rd_addr];
    line_pt  = ~bank_pt[rd_addr];
    line_pc  = ~bank_pc[rd_addr];
    sns_true = ~line_t;
    sns_comp = ~line_c;
    sns_pt   = ~line_pt;
    sns_pc   = ~line_pc;
  end

  // R2: a write leaves true, inverse and parity pair in their defined relation
  a_r2_write_nodes: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (bank_t[$past(wr_addr)] == $past(wr_data)) &&
              (bank_c[$past(wr_addr)] == ~$past(wr_data)) &&
              (bank_pt[$past(wr_addr)] == ^$past(wr_data)) &&
              (bank_pc[$past(wr_addr)] != bank_pt[$past(wr_addr)]));

  // R8: a data true-node fault flips that node and leaves the inverse node alone
  a_r8_fault_true_only: assert property (@(posedge clk) disable iff (rst)
    (flt_live && flt_sel == NODE_DT && !(wr_en && wr_addr == flt_addr)) |=>
      (bank_t[$past(flt_addr)][$past(flt_bit)] != $past(bank_t[flt_addr][flt_bit])) &&
      (bank_c[$past(flt_addr)] == $past(bank_c[flt_addr])));

  // R8: a parity true-node fault leaves the parity inverse node alone
  a_r8_fault_par_only: assert property (@(posedge clk) disable iff (rst)
    (flt_live && flt_sel == NODE_PT) |=>
      (bank_pt[$past(flt_addr)] != $past(bank_pt[flt_addr])) &&
      (bank_pc[$past(flt_addr)] == $past(bank_pc[flt_addr])));

endmodule

// File: rtl/drpr_decode.sv
module drpr_decode #(
  parameter int W = 16
) (
  input  logic [W-1:0] sns_true,
  input  logic [W-1:0] sns_comp,
  input  logic         sns_pt,
  input  logic         sns_pc,
  output logic [W-1:0] dec_data,
  output logic         dec_corr,
  output logic         dec_unc,
  output logic         dec_single
);

  logic [W-1:0] bit_bad;

  // One disagreement detector per bit position
  for (genvar gi = 0; gi < W; gi++) begin : g_pair
    assign bit_bad[gi] = (sns_true[gi] == sns_comp[gi]);
  end

  int           n_bad;
  logic         par_bad;
  logic         good_par;
  logic         fix_val;
  logic [W-1:0] repaired;

  always_comb begin
    n_bad      = $countones(bit_bad);
    par_bad    = (sns_pt == sns_pc);
    good_par   = ^(sns_true & ~bit_bad);
    fix_val    = sns_pt ^ good_par;
    repaired   = (sns_true & ~bit_bad) | ({W{fix_val}} & bit_bad);
    dec_single = (n_bad == 1) && !par_bad;
    dec_data   = sns_true;
    dec_corr   = 1'b0;
    dec_unc    = 1'b0;
    if (n_bad == 0) begin
      if (par_bad)                      dec_corr = 1'b1;
      else if ((^sns_true) != sns_pt)   dec_unc  = 1'b1;
    end else if (dec_single) begin
      dec_data = repaired;
      dec_corr = 1'b1;
    end else begin
      dec_unc = 1'b1;
    end
  end

endmodule

// File: rtl/drpr_ram.sv
module drpr_ram
  import drpr_pkg::*;
#(
  parameter int W  = 16,
  parameter int D  = 32,
  parameter int AW = (D > 1) ? $clog2(D) : 1,
  parameter int BW = bit_idx_w(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          flt_en,
  input  logic [AW-1:0] flt_addr,
  input  logic [1:0]    flt_sel,
  input  logic [BW-1:0] flt_bit,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic          rd_corrected,
  output logic          rd_uncorrectable
);

  logic [W-1:0] sns_true, sns_comp, dec_data;
  logic         sns_pt, sns_pc, dec_corr, dec_unc, dec_single;

  drpr_store #(.W(W), .D(D), .AW(AW), .BW(BW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .flt_en   (flt_en),
    .flt_addr (flt_addr),
    .flt_sel  (node_sel_e'(flt_sel)),
    .flt_bit  (flt_bit),
    .sns_true (sns_true),
    .sns_comp (sns_comp),
    .sns_pt   (sns_pt),
    .sns_pc   (sns_pc)
  );

  drpr_decode #(.W(W)) u_decode (
    .sns_true   (sns_true),
    .sns_comp   (sns_comp),
    .sns_pt     (sns_pt),
    .sns_pc     (sns_pc),
    .dec_data   (dec_data),
    .dec_corr   (dec_corr),
    .dec_unc    (dec_unc),
    .dec_single (dec_single)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid         <= 1'b0;
      rd_data          <= '0;
      rd_corrected     <= 1'b0;
      rd_uncorrectable <= 1'b0;
    end else begin
      rd_valid         <= rd_en;
      rd_corrected     <= rd_en & dec_corr;
      rd_uncorrectable <= rd_en & dec_unc;
      if (rd_en) rd_data <= dec_data;
    end
  end

  // R3: an accepted read produces a result one cycle later
  a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R10: flags never both set
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_corrected && rd_uncorrectable));

  // R10: no flags outside a read result
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (!rd_corrected && !rd_uncorrectable));

  // R5: a single-bit repair yields a word whose parity matches the stored bit
  a_r5_repair_parity: assert property (@(posedge clk) disable iff (rst)
    (rd_en && dec_single) |-> ((^dec_data) == sns_pt));

endmodule

// File: tb/drpr_ram_bench.sv
module drpr_ram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int D  = 32;
  localparam int AW = $clog2(D);
  localparam int BW = $clog2(W);
  localparam int NN = 2 * W + 2;  // nodes per word

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          flt_en = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [1:0]    flt_sel = '0;
  logic [BW-1:0] flt_bit = '0;
  logic          rd_valid, rd_corrected, rd_uncorrectable;
  logic [W-1:0]  rd_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drpr_ram #(.W(W), .D(D)) u_drpr_ram (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .flt_en(flt_en), .flt_addr(flt_addr), .flt_sel(flt_sel), .flt_bit(flt_bit),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_corrected(rd_corrected), .rd_uncorrectable(rd_uncorrectable)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_fault(input logic [AW-1:0] a, input int node);
    @(negedge clk);
    flt_en = 1'b1; flt_addr = a;
    if (node < W)          begin flt_sel = 2'd0; flt_bit = BW'(node); end
    else if (node < 2 * W) begin flt_sel = 2'd1; flt_bit = BW'(node - W); end
    else if (node == 2 * W) flt_sel = 2'd2;
    else                    flt_sel = 2'd3;
    @(negedge clk); flt_en = 1'b0;
  endtask

  // Issue a read; on return outputs hold the registered result
  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk_read(input string tag, input logic [W-1:0] exp_d, input bit exp_c, input bit exp_u);
    chk(rd_valid, {tag, " valid"}, W'(rd_valid), W'(1));
    chk(rd_data == exp_d, {tag, " data"}, rd_data, exp_d);
    chk(rd_corrected == exp_c, {tag, " corrected"}, W'(rd_corrected), W'(exp_c));
    chk(rd_uncorrectable == exp_u, {tag, " uncorrectable"}, W'(rd_uncorrectable), W'(exp_u));
  endtask

  function automatic logic [W-1:0] pat(input int k);
    return W'(k * 40503 + 7);
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rd_valid && !rd_corrected && !rd_uncorrectable, "R1 flags in reset", W'(rd_valid), '0);
    chk(rd_data == '0, "R1 data in reset", rd_data, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_valid && !rd_corrected && !rd_uncorrectable && rd_data == '0,
        "R1 after reset", rd_data, '0);
  endtask

  task automatic t_clean;
    logic [W-1:0] v [4];
    v[0] = '0; v[1] = '1; v[2] = 16'hA5A5; v[3] = 16'h0001;
    for (int i = 0; i < 4; i++) do_write(AW'(i * 9), v[i]);
    for (int i = 0; i < 4; i++) begin
      do_read(AW'(i * 9));
      chk_read("R2 clean read", v[i], 1'b0, 1'b0);
    end
    // R3: result lasts one cycle only
    @(negedge clk);
    chk(!rd_valid, "R3 valid single cycle", W'(rd_valid), '0);
    // R10: data held between reads
    chk(rd_data == v[3], "R10 data held", rd_data, v[3]);
  endtask

  task automatic t_rdw;
    do_write(AW'(5), 16'h1111);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(5); wr_data = 16'h2222;
    rd_en = 1'b1; rd_addr = AW'(5);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk_read("R4 read during write", 16'h1111, 1'b0, 1'b0);
    do_read(AW'(5));
    chk_read("R4 new data after", 16'h2222, 1'b0, 1'b0);
  endtask

  task automatic t_single;
    for (int n = 0; n < NN; n++) begin
      logic [W-1:0] p = pat(n);
      do_write(AW'(3), p);
      do_fault(AW'(3), n);
      do_read(AW'(3));
      if (n < 2 * W) chk_read("R5 single data upset", p, 1'b1, 1'b0);
      else           chk_read("R6 single parity upset", p, 1'b1, 1'b0);
    end
  endtask

  task automatic t_double;
    for (int a = 0; a < NN; a++) begin
      for (int b = a + 1; b < NN; b++) begin
        logic [W-1:0] p = pat(a * NN + b);
        logic [W-1:0] m = '0;
        if (a < W) m[a] = 1'b1;
        if (b < W) m[b] = 1'b1;
        do_write(AW'(17), p);
        do_fault(AW'(17), a);
        do_fault(AW'(17), b);
        do_read(AW'(17));
        chk_read("R7 double upset", p ^ m, 1'b0, 1'b1);
      end
    end
  endtask

  task automatic t_isolation;
    do_write(AW'(8), 16'h3C3C);
    do_write(AW'(9), 16'hC3C3);
    do_fault(AW'(8), 2);
    do_fault(AW'(8), W + 7);
    do_read(AW'(9));
    chk_read("R8 neighbour untouched", 16'hC3C3, 1'b0, 1'b0);
    do_read(AW'(8));
    chk_read("R8 target hit twice", 16'h3C3C ^ 16'h0004, 1'b0, 1'b1);
  endtask

  task automatic t_write_wins;
    do_write(AW'(12), 16'h0F0F);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(12); wr_data = 16'h7E81;
    flt_en = 1'b1; flt_addr = AW'(12); flt_sel = 2'd0; flt_bit = BW'(4);
    @(negedge clk);
    wr_en = 1'b0; flt_en = 1'b0;
    do_read(AW'(12));
    chk_read("R9 write beats fault", 16'h7E81, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset;
    t_clean;
    t_rdw;
    t_single;
    t_double;
    t_isolation;
    t_write_wins;
    @(negedge clk);
    chk(!rd_valid && !rd_corrected && !rd_uncorrectable, "R10 idle quiet", W'(rd_corrected), '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule